// File: doc/BRIEF.md
# Vector Across-Lane Reduction Unit

This unit folds every lane of a 128-bit vector operand into one scalar. The scalar is the signed maximum, the unsigned maximum, the signed minimum, the unsigned minimum, or the wrapping sum of the lanes. The operation is chosen by an already extracted set of fields: a 5-bit operation code, a signedness bit, a 2-bit lane size and a width bit. The width bit selects either the whole register or only its low 64 bits. Register-file access and instruction decode stay outside the unit.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream. A request is taken on any clock edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register until the consumer raises `out_ready`. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer without losing a result. Encodings the unit does not support still produce an output beat: it carries an illegal flag and an all-zero result.

Top module: `simd_red_unit`

## Requirements
- R1: Opcode 01010 selects maximum and opcode 11010 selects minimum. Signedness bit 0 compares the lanes as two's-complement values, and 1 compares them as unsigned values.
- R2: Opcode 11011 with signedness bit 0 sums the lanes, modulo 2^lane-width, with no saturation and no carry-out.
- R3: The illegal flag is set, and the result is all zero, for any of these: an opcode outside {01010, 11010, 11011}, opcode 11011 with signedness bit 1, lane size 11, or lane size 10 with width bit 0.
- R4: Lane size 00, 01 and 10 select 8-, 16- and 32-bit lanes. With width bit 0, maximum and minimum reduce only the lanes of bits [63:0].
- R5: With width bit 0, the sum covers only the lanes of bits [63:0]. Bits [127:64] of the operand add nothing.
- R6: The reduced scalar sits in the least significant lane of `out_data`, and every higher bit of `out_data` is zero.
- R7: A request accepted at clock edge N shows `out_valid` high, with its result and flag, from edge N onward. `out_valid` falls at the next edge where `out_ready` is high and no new request is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_illegal` hold their values.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_data | input | 128 | Vector operand |
| in_u | input | 1 | Signedness bit (1 = unsigned) |
| in_opcode | input | 5 | Operation code |
| in_size | input | 2 | Lane size code |
| in_q | input | 1 | Width bit (1 = full 128 bits, 0 = low 64 bits) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Scalar result in the low lane, zero above |
| out_illegal | output | 1 | Request used an unsupported encoding |

## Verification
Every result is due exactly one clock edge after its request is accepted. The bench therefore drives each request at a falling edge, lets one rising edge pass, and compares `out_valid`, `out_illegal` and `out_data` at the next falling edge. Stall cases hold `out_ready` low and repeat the comparison at later falling edges, to show that the register keeps its value and does not take a new request. The sweep covers every lane size, both width settings, every supported opcode and one unsupported opcode, and both signedness values, over fixed and random operands. Each expected scalar is computed by a sequential lane loop in the bench, not by a halving tree.

// File: rtl/simd_red_pkg.sv
package simd_red_pkg;

  typedef enum logic [2:0] {
    RK_SMAX = 3'd0,
    RK_UMAX = 3'd1,
    RK_SMIN = 3'd2,
    RK_UMIN = 3'd3,
    RK_ADD  = 3'd4
  } red_kind_e;

  localparam logic [4:0] OPC_MAX = 5'b01010;
  localparam logic [4:0] OPC_MIN = 5'b11010;
  localparam logic [4:0] OPC_SUM = 5'b11011;

  // number of supported lane sizes (8, 16, 32 bits)
  localparam int NUM_SIZES = 3;

endpackage

// File: rtl/simd_red_decode.sv
module simd_red_decode
  import simd_red_pkg::*;
(
  input  logic       u_bit,
  input  logic [4:0] opcode,
  input  logic [1:0] size,
  input  logic       q_bit,
  output red_kind_e  kind,
  output logic       illegal
);

  logic op_bad;

  always_comb begin
    kind   = RK_ADD;
    op_bad = 1'b0;
    unique case (opcode)
      OPC_MAX: kind = u_bit ? RK_UMAX : RK_SMAX;
      OPC_MIN: kind = u_bit ? RK_UMIN : RK_SMIN;
      OPC_SUM: begin
        kind   = RK_ADD;
        op_bad = u_bit;
      end
      default: op_bad = 1'b1;
    endcase
  end

  // size 11 has no lane width here; two 32-bit lanes are not supported
  assign illegal = op_bad
                 || (int'(size) >= NUM_SIZES)
                 || (size == 2'b10 && !q_bit);

endmodule

// File: rtl/simd_red_op.sv
module simd_red_op
  import simd_red_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  red_kind_e         kind,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] y
);

  logic [LANE_W-1:0] a_bias, b_bias;
  logic              lt_s, lt_u;

  // flipping the sign bit turns a signed compare into an unsigned one
  assign a_bias = {~a[LANE_W-1], a[LANE_W-2:0]};
  assign b_bias = {~b[LANE_W-1], b[LANE_W-2:0]};
  assign lt_s   = a_bias < b_bias;
  assign lt_u   = a < b;

  always_comb begin
    unique case (kind)
      RK_SMAX: y = lt_s ? b : a;
      RK_UMAX: y = lt_u ? b : a;
      RK_SMIN: y = lt_s ? a : b;
      RK_UMIN: y = lt_u ? a : b;
      RK_ADD:  y = a + b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/simd_red_tree.sv
module simd_red_tree
  import simd_red_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  red_kind_e         kind,
  input  logic [DATA_W-1:0] vec,
  output logic [LANE_W-1:0] scalar
);

  localparam int NLANES = DATA_W / LANE_W;
  localparam int LEVELS = $clog2(NLANES);

  wire [DATA_W-1:0] stg [LEVELS+1];

  assign stg[0] = vec;

  // each level combines the upper half of the live lanes with the lower half
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int HALF_LANES = NLANES >> (lv + 1);
    localparam int HALF_BITS  = HALF_LANES * LANE_W;
    for (genvar ln = 0; ln < HALF_LANES; ln++) begin : g_lane
      simd_red_op #(.LANE_W(LANE_W)) u_op (
        .kind (kind),
        .a    (stg[lv][ln*LANE_W +: LANE_W]),
        .b    (stg[lv][HALF_BITS + ln*LANE_W +: LANE_W]),
        .y    (stg[lv+1][ln*LANE_W +: LANE_W])
      );
    end
    assign stg[lv+1][DATA_W-1:HALF_BITS] = '0;
  end

  assign scalar = stg[LEVELS][LANE_W-1:0];

endmodule

// File: rtl/simd_red_unit.sv
module simd_red_unit
  import simd_red_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int BASE_LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_u,
  input  logic [4:0]        in_opcode,
  input  logic [1:0]        in_size,
  input  logic              in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);

  localparam int HALF_W     = DATA_W / 2;
  localparam int MAX_LANE_W = BASE_LANE_W << (NUM_SIZES - 1);

  red_kind_e         kind;
  logic              illegal;
  logic [DATA_W-1:0] prepped;
  logic [DATA_W-1:0] next_data;
  wire  [MAX_LANE_W-1:0] red_by_size [NUM_SIZES];

  simd_red_decode u_dec (
    .u_bit   (in_u),
    .opcode  (in_opcode),
    .size    (in_size),
    .q_bit   (in_q),
    .kind    (kind),
    .illegal (illegal)
  );

  // half width: the sum clears the top half, max/min mirror the bottom half
  always_comb begin
    if (in_q)
      prepped = in_data;
    else if (kind == RK_ADD)
      prepped = {{HALF_W{1'b0}}, in_data[HALF_W-1:0]};
    else
      prepped = {in_data[HALF_W-1:0], in_data[HALF_W-1:0]};
  end

  for (genvar sz = 0; sz < NUM_SIZES; sz++) begin : g_size
    localparam int LW = BASE_LANE_W << sz;
    logic [LW-1:0] lane_res;
    simd_red_tree #(.DATA_W(DATA_W), .LANE_W(LW)) u_tree (
      .kind   (kind),
      .vec    (prepped),
      .scalar (lane_res)
    );
    assign red_by_size[sz] = MAX_LANE_W'(lane_res);
  end

  always_comb begin
    next_data = '0;
    if (!illegal && int'(in_size) < NUM_SIZES)
      next_data = DATA_W'(red_by_size[in_size]);
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_data    <= next_data;
      out_illegal <= illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_red_sva.sv
module simd_red_sva #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_size,
  input logic              in_q,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);

  // R7: an accepted request is presented on the next edge
  a_r7_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: a stalled result holds
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_illegal));

  // R8: no acceptance while stalled
  a_r8_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3: illegal beats carry a zero result
  a_r3_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_data == '0);

  // R3: size 11 and size 10 at half width are flagged
  a_r3_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_size == 2'b11 || (in_size == 2'b10 && !in_q))
    |=> out_illegal);

  // R6: nothing above the widest lane
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[DATA_W-1:32] == '0);

  // R9: an empty output register accepts
  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind simd_red_unit simd_red_sva #(.DATA_W(DATA_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_size     (in_size),
  .in_q        (in_q),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/simd_red_unit_test.sv
`timescale 1ns/1ps
module simd_red_unit_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_u = 1'b0;
  logic [4:0]   in_opcode = '0;
  logic [1:0]   in_size = '0;
  logic         in_q = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_illegal;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  simd_red_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_u(in_u), .in_opcode(in_opcode), .in_size(in_size), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_illegal(input logic u, input logic [4:0] opc,
                                         input logic [1:0] sz, input logic q);
    logic ok_op;
    ok_op = (opc == 5'b01010) || (opc == 5'b11010) || (opc == 5'b11011 && !u);
    return !ok_op || sz == 2'b11 || (sz == 2'b10 && !q);
  endfunction

  function automatic longint sx(input longint v, input int lw);
    if ((v >> (lw - 1)) & 1) return v - (longint'(1) << lw);
    return v;
  endfunction

  // sequential reference over the lanes that count
  function automatic logic [127:0] model(input logic [127:0] d, input logic u,
                                         input logic [4:0] opc, input logic [1:0] sz,
                                         input logic q);
    int     lw, n;
    longint mask, acc, v;
    if (model_illegal(u, opc, sz, q)) return '0;
    lw   = 8 << sz;
    n    = (q ? 128 : 64) / lw;
    mask = (longint'(1) << lw) - 1;
    acc  = longint'(d[31:0]) & mask;
    for (int i = 1; i < n; i++) begin
      logic [127:0] sh;
      sh = d >> (i * lw);
      v  = longint'(sh[31:0]) & mask;
      if (opc == 5'b11011) acc = (acc + v) & mask;
      else if (opc == 5'b01010) begin
        if (u) begin if (v > acc) acc = v; end
        else if (sx(v, lw) > sx(acc, lw)) acc = v;
      end else begin
        if (u) begin if (v < acc) acc = v; end
        else if (sx(v, lw) < sx(acc, lw)) acc = v;
      end
    end
    return 128'(acc);
  endfunction

  function automatic string tag(input logic u, input logic [4:0] opc,
                                input logic [1:0] sz, input logic q);
    if (model_illegal(u, opc, sz, q)) return "R3";
    if (!q && opc == 5'b11011) return "R5";
    if (!q) return "R4";
    if (opc == 5'b11011) return "R2";
    return "R1";
  endfunction

  task automatic run_one(input logic [127:0] d, input logic u, input logic [4:0] opc,
                         input logic [1:0] sz, input logic q);
    logic [127:0] exp_d;
    string t;
    exp_d = model(d, u, opc, sz, q);
    t = tag(u, opc, sz, q);
    @(negedge clk);
    in_data = d; in_u = u; in_opcode = opc; in_size = sz; in_q = q;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid", 128'(out_valid), 128'(1));
    chk({t, " illegal"}, 128'(out_illegal), 128'(model_illegal(u, opc, sz, q)));
    chk({t, " data"}, out_data, exp_d);
    chk("R6 upper", 128'(out_data[127:32]), 128'(0));
  endtask

  logic [4:0] opcs [4] = '{5'b01010, 5'b11010, 5'b11011, 5'b00111};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    logic [127:0] ea, eb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid in reset", 128'(out_valid), 128'(0));
    chk("R9 in_ready in reset", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", 128'(out_valid), 128'(0));

    // directed: byte sum of all-ones wraps to 0xF0 (R2)
    run_one({16{8'hFF}}, 1'b0, 5'b11011, 2'b00, 1'b1);
    chk("R2 wrap", out_data, 128'hF0);
    // half-width sum ignores bits [127:64] (R5)
    run_one({{8{8'h11}}, {8{8'h01}}}, 1'b0, 5'b11011, 2'b00, 1'b0);
    chk("R5 low half only", out_data, 128'h08);

    for (int p = 0; p < 8; p++) begin
      case (p)
        0: pat = {16{8'hFF}};
        1: pat = {16{8'h80}};
        2: pat = {8{16'h7F80}};
        3: for (int b = 0; b < 16; b++) pat[b*8 +: 8] = 8'(b * 17 + 3);
        default: pat = {$urandom, $urandom, $urandom, $urandom};
      endcase
      for (int oi = 0; oi < 4; oi++)
        for (int uu = 0; uu < 2; uu++)
          for (int sz = 0; sz < 4; sz++)
            for (int qq = 0; qq < 2; qq++)
              run_one(pat, 1'(uu), opcs[oi], 2'(sz), 1'(qq));
    end

    // back-pressure: R8
    @(negedge clk);
    ea = model({4{32'h0000_0005}}, 1'b0, 5'b11011, 2'b10, 1'b1);
    eb = model({4{32'h0000_0009}}, 1'b1, 5'b01010, 2'b10, 1'b1);
    in_data = {4{32'h0000_0005}}; in_u = 1'b0; in_opcode = 5'b11011;
    in_size = 2'b10; in_q = 1'b1; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_data = {4{32'h0000_0009}}; in_u = 1'b1; in_opcode = 5'b01010;
    chk("R8 valid while stalled", 128'(out_valid), 128'(1));
    chk("R8 in_ready low", 128'(in_ready), 128'(0));
    chk("R8 data first", out_data, ea);
    @(posedge clk);
    @(negedge clk);
    chk("R8 data held", out_data, ea);
    chk("R8 in_ready still low", 128'(in_ready), 128'(0));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second result", out_data, eb);
    chk("R7 second valid", 128'(out_valid), 128'(1));
    @(posedge clk);
    @(negedge clk);
    chk("R7 drained", 128'(out_valid), 128'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule